// File: doc/BRIEF.md
# Three-by-three box-average image filter engine

This block smooths a small 8-bit grayscale image. Each output pixel is the mean of the nine input pixels in the 3x3 window centred on it. The input image sits row-major in an external memory with a flat address. The engine reads that memory through a read port whose data arrives one cycle after the address. It writes results to a second external memory through a plain write port.

A pulse on `start` launches a sequencer. The sequencer walks every interior pixel in raster order. For each one it hands a 5-bit row, a 5-bit column and the output address to a per-pixel core, and raises a one-cycle operation request. The core turns the centre position into nine flat read addresses by stepping a row and a column offset through -1, 0 and +1. It adds the nine fetched bytes, divides the total by nine with a constant reciprocal multiply, and writes the quotient. It then signals completion, and only then does the sequencer issue the next pixel. After the last pixel the engine drops `busy` and holds `all_done` until the next start.

The outermost rows and columns have incomplete windows, so they are never computed or written. The caller keeps those output entries at zero.

Top module: `box_mean_engine`

## Requirements
- R1: During reset and on the first cycle after it, `busy`, `all_done`, `rd_en` and `wr_en` are all low.
- R2: A `start` pulse seen while idle makes `busy` high one cycle later. A `start` pulse seen while busy has no effect: every output entry is still written exactly once, with the correct value.
- R3: The value written for centre (r,c) is floor(S/9), where S is the sum of the nine input pixels at rows r-1..r+1 and columns c-1..c+1.
- R4: Read addresses are flat: (row)*18 + (column). For each pixel the nine reads come with the column offset in the inner loop and the row offset in the outer loop, both going -1, 0, +1. For centre (1,1) the order is 0,1,2,18,19,20,36,37,38.
- R5: Exactly nine reads are issued per output pixel, so a full run makes 16*16*9 = 2304 reads.
- R6: Only rows 1..16 and columns 1..16 are written. Each such entry is written exactly once per run, at address row*18+column. No border address (row or column 0 or 17) is ever written.
- R7: Pixels are written in raster order, so within a run each write address is strictly greater than the one before.
- R8: `rd_data` is used only in the cycle after the matching `rd_en`. Values present on `rd_data` in other cycles do not affect any result.
- R9: When the last pixel completes, `busy` falls and `all_done` rises in the same cycle. `all_done` then stays high until the next accepted `start`.
- R10: Extreme inputs do not overflow. An all-255 image gives 255 at every interior pixel, and an all-0 image gives 0.
- R11: A new `start` after completion clears `all_done` one cycle later and runs the whole image again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to filter the whole image |
| busy | output | 1 | High while a run is in progress |
| all_done | output | 1 | High from the end of a run until the next start |
| rd_en | output | 1 | Input-memory read strobe |
| rd_addr | output | 9 | Flat input-memory read address |
| rd_data | input | 8 | Input pixel, valid the cycle after `rd_en` |
| wr_en | output | 1 | Output-memory write strobe |
| wr_addr | output | 9 | Flat output-memory write address |
| wr_data | output | 8 | Filtered pixel value |

## Verification
The assertions take three things for granted. Every centre handed to the core lies strictly inside the image, so all nine neighbours exist. A new operation reaches the core only after the previous one has signalled completion. The input memory returns data exactly one cycle after a read strobe. The stimulus keeps within these by driving the engine only through `start`, by modelling the input memory with a one-cycle registered read that returns junk in every cycle without a read, and by letting the built-in sequencer produce all coordinates. Images are chosen so the sums hit both ends of the range and both parities of a checkerboard, which exercises the truncating division near every remainder.

// File: rtl/mf_pkg.sv
package mf_pkg;

  typedef enum logic [1:0] {
    S_IDLE,
    S_ISSUE,
    S_WAIT
  } sched_st_t;

  typedef enum logic [1:0] {
    C_IDLE,
    C_ISSUE,
    C_DRAIN,
    C_WRITE
  } core_st_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/mf_div9.sv
module mf_div9 #(
  parameter int SUM_W = 12,
  parameter int Q_W   = 8
) (
  input  logic [SUM_W-1:0] dividend,
  output logic [Q_W-1:0]   quotient
);
  // floor(x/9) = (x*M) >> SH with M = ceil(2^SH/9); exact for x < 2^SUM_W
  localparam int SH     = SUM_W + 3;
  localparam int PROD_W = 2 * SUM_W + 4;
  localparam logic [PROD_W-1:0] RECIP = PROD_W'(((64'd1 << SH) + 64'd8) / 64'd9);

  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] shifted;

  always_comb begin
    prod     = PROD_W'(dividend) * RECIP;
    shifted  = prod >> SH;
    quotient = Q_W'(shifted);
  end
endmodule

// File: rtl/mf_pixel_core.sv
module mf_pixel_core
  import mf_pkg::*;
#(
  parameter int IMG_W   = 18,
  parameter int IMG_H   = 18,
  parameter int PIX_W   = 8,
  parameter int COORD_W = 5,
  parameter int ADDR_W  = 9,
  parameter int SUM_W   = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               op_start,
  input  logic [COORD_W-1:0] op_row,
  input  logic [COORD_W-1:0] op_col,
  input  logic [ADDR_W-1:0]  op_addr,
  output logic               op_done,
  output logic               rd_en,
  output logic [ADDR_W-1:0]  rd_addr,
  input  logic [PIX_W-1:0]   rd_data,
  output logic               wr_en,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [PIX_W-1:0]   wr_data
);
  localparam logic [ADDR_W-1:0] ROW_STEP = ADDR_W'(IMG_W);
  localparam logic [ADDR_W-1:0] CORNER   = ADDR_W'(IMG_W + 1);

  core_st_t          st;
  logic [ADDR_W-1:0] centre;
  logic [ADDR_W-1:0] dest;
  logic [1:0]        kr, kc;
  logic [SUM_W-1:0]  acc;
  logic [SUM_W-1:0]  acc_next;
  logic              data_vld;
  logic [PIX_W-1:0]  quot;

  always_comb begin
    acc_next = data_vld ? (acc + SUM_W'(rd_data)) : acc;
  end

  mf_div9 #(.SUM_W(SUM_W), .Q_W(PIX_W)) u_div (
    .dividend (acc_next),
    .quotient (quot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= C_IDLE;
      centre   <= '0;
      dest     <= '0;
      kr       <= '0;
      kc       <= '0;
      acc      <= '0;
      data_vld <= 1'b0;
      rd_en    <= 1'b0;
      rd_addr  <= '0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      op_done  <= 1'b0;
    end else begin
      data_vld <= rd_en;
      acc      <= acc_next;
      op_done  <= 1'b0;
      unique case (st)
        C_IDLE: begin
          if (op_start) begin
            centre <= ADDR_W'(op_row) * ROW_STEP + ADDR_W'(op_col);
            dest   <= op_addr;
            kr     <= '0;
            kc     <= '0;
            acc    <= '0;
            st     <= C_ISSUE;
          end
        end
        C_ISSUE: begin
          rd_en   <= 1'b1;
          rd_addr <= centre + ADDR_W'(kr) * ROW_STEP + ADDR_W'(kc) - CORNER;
          if (kc == 2'd2) begin
            kc <= '0;
            kr <= kr + 2'd1;
            if (kr == 2'd2) st <= C_DRAIN;
          end else begin
            kc <= kc + 2'd1;
          end
        end
        C_DRAIN: begin
          rd_en <= 1'b0;
          if (data_vld && !rd_en) begin
            wr_en   <= 1'b1;
            wr_addr <= dest;
            wr_data <= quot;
            st      <= C_WRITE;
          end
        end
        C_WRITE: begin
          wr_en   <= 1'b0;
          op_done <= 1'b1;
          st      <= C_IDLE;
        end
        default: st <= C_IDLE;
      endcase
    end
  end

  // Read counter kept only for the checks below
  logic [3:0] rd_cnt;
  always_ff @(posedge clk) begin
    if (rst) rd_cnt <= '0;
    else if (st == C_IDLE && op_start) rd_cnt <= '0;
    else if (rd_en) rd_cnt <= rd_cnt + 4'd1;
  end

  a_r5_nine_reads: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> rd_cnt == 4'd9);

  a_r4_read_in_image: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> int'(rd_addr) < IMG_W * IMG_H);

  a_r6_centre_interior: assert property (@(posedge clk) disable iff (rst)
    (op_start && st == C_IDLE) |->
      (op_row >= COORD_W'(1) && op_row <= COORD_W'(IMG_H - 2) &&
       op_col >= COORD_W'(1) && op_col <= COORD_W'(IMG_W - 2)));

  a_r9_done_follows_write: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (op_done && !wr_en));

  a_r8_no_read_during_write: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !rd_en);
endmodule

// File: rtl/mf_scheduler.sv
module mf_scheduler
  import mf_pkg::*;
#(
  parameter int IMG_W   = 18,
  parameter int IMG_H   = 18,
  parameter int COORD_W = 5,
  parameter int ADDR_W  = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               op_done,
  output logic               op_start,
  output logic [COORD_W-1:0] op_row,
  output logic [COORD_W-1:0] op_col,
  output logic [ADDR_W-1:0]  op_addr,
  output logic               busy,
  output logic               all_done
);
  localparam logic [COORD_W-1:0] FIRST    = COORD_W'(1);
  localparam logic [COORD_W-1:0] LAST_ROW = COORD_W'(IMG_H - 2);
  localparam logic [COORD_W-1:0] LAST_COL = COORD_W'(IMG_W - 2);

  sched_st_t          st;
  logic [COORD_W-1:0] r, c;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      r        <= FIRST;
      c        <= FIRST;
      op_start <= 1'b0;
      op_row   <= '0;
      op_col   <= '0;
      op_addr  <= '0;
      busy     <= 1'b0;
      all_done <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (start) begin
            r        <= FIRST;
            c        <= FIRST;
            busy     <= 1'b1;
            all_done <= 1'b0;
            st       <= S_ISSUE;
          end
        end
        S_ISSUE: begin
          op_start <= 1'b1;
          op_row   <= r;
          op_col   <= c;
          op_addr  <= ADDR_W'(r) * ADDR_W'(IMG_W) + ADDR_W'(c);
          st       <= S_WAIT;
        end
        S_WAIT: begin
          op_start <= 1'b0;
          if (op_done) begin
            if (r == LAST_ROW && c == LAST_COL) begin
              busy     <= 1'b0;
              all_done <= 1'b1;
              st       <= S_IDLE;
            end else begin
              if (c == LAST_COL) begin
                c <= FIRST;
                r <= r + COORD_W'(1);
              end else begin
                c <= c + COORD_W'(1);
              end
              st <= S_ISSUE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    all_done |-> !busy);

  a_r2_busy_holds_on_start: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !op_done) |=> busy);

  a_r7_request_is_pulse: assert property (@(posedge clk) disable iff (rst)
    op_start |=> !op_start);

  a_r11_start_clears_done: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && start) |=> (busy && !all_done));
endmodule

// File: rtl/box_mean_engine.sv
module box_mean_engine
  import mf_pkg::*;
#(
  parameter int IMG_W = 18,
  parameter int IMG_H = 18,
  parameter int PIX_W = 8,
  localparam int ADDR_W = $clog2(IMG_W * IMG_H)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic              all_done,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [PIX_W-1:0]  rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [PIX_W-1:0]  wr_data
);
  localparam int COORD_W = $clog2(max2(IMG_W, IMG_H));
  localparam int SUM_W   = PIX_W + 4;

  logic               op_start, op_done;
  logic [COORD_W-1:0] op_row, op_col;
  logic [ADDR_W-1:0]  op_addr;

  mf_scheduler #(
    .IMG_W(IMG_W), .IMG_H(IMG_H), .COORD_W(COORD_W), .ADDR_W(ADDR_W)
  ) u_sched (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .op_done  (op_done),
    .op_start (op_start),
    .op_row   (op_row),
    .op_col   (op_col),
    .op_addr  (op_addr),
    .busy     (busy),
    .all_done (all_done)
  );

  mf_pixel_core #(
    .IMG_W(IMG_W), .IMG_H(IMG_H), .PIX_W(PIX_W),
    .COORD_W(COORD_W), .ADDR_W(ADDR_W), .SUM_W(SUM_W)
  ) u_core (
    .clk      (clk),
    .rst      (rst),
    .op_start (op_start),
    .op_row   (op_row),
    .op_col   (op_col),
    .op_addr  (op_addr),
    .op_done  (op_done),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

  a_r6_write_interior: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (int'(wr_addr) % IMG_W != 0 && int'(wr_addr) % IMG_W != IMG_W - 1 &&
               int'(wr_addr) >= IMG_W && int'(wr_addr) < IMG_W * (IMG_H - 1)));

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !all_done && !rd_en && !wr_en));
endmodule

// File: tb/box_mean_engine_tb.sv
`timescale 1ns/1ps
module box_mean_engine_tb;
  localparam int W = 18;
  localparam int H = 18;
  localparam int N = W * H;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       busy, all_done, rd_en, wr_en;
  logic [8:0] rd_addr, wr_addr;
  logic [7:0] rd_data, wr_data;

  always #2.5 clk = ~clk;

  box_mean_engine u_dut (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .all_done(all_done),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  int img [N];
  int omem [N];
  int wcnt [N];
  int wr_total, rd_total, order_bad, last_wr, rd_log_n;
  int rd_log [9];
  bit wr_seen;
  logic [7:0] junk = 8'h3C;
  int n_chk = 0, n_fail = 0;
  int cycles = 0;
  bit finished = 0;

  // Input memory model: one-cycle read, junk when not reading (R8)
  always @(posedge clk) begin
    cycles <= cycles + 1;
    junk   <= {junk[6:0], junk[7] ^ junk[5] ^ junk[4] ^ junk[3]};
    if (rd_en) rd_data <= 8'(img[rd_addr]);
    else       rd_data <= junk;
    if (rd_en) begin
      rd_total++;
      if (rd_log_n < 9) begin
        rd_log[rd_log_n] = int'(rd_addr);
        rd_log_n++;
      end
    end
    if (wr_en) begin
      omem[wr_addr] = int'(wr_data);
      wcnt[wr_addr]++;
      if (wr_seen && int'(wr_addr) <= last_wr) order_bad++;
      last_wr = int'(wr_addr);
      wr_seen = 1;
      wr_total++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic fill(input int kind);
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) begin
        int v;
        case (kind)
          0: v = (r * 7 + c * 13) & 255;
          1: v = 255;
          2: v = 0;
          3: v = ((r + c) & 1) ? 255 : 0;
          default: v = (r * r * 31 + c * 17 + r * c * 5 + 3) & 255;
        endcase
        img[r * W + c] = v;
      end
  endtask

  function automatic int expect_at(input int r, input int c);
    int s = 0;
    for (int dr = -1; dr <= 1; dr++)
      for (int dc = -1; dc <= 1; dc++)
        s += img[(r + dr) * W + (c + dc)];
    return s / 9;
  endfunction

  task automatic run_image(input int kind, input string tag, input bit poke_start);
    int guard;
    fill(kind);
    for (int i = 0; i < N; i++) begin omem[i] = 0; wcnt[i] = 0; end
    wr_total = 0; rd_total = 0; order_bad = 0; last_wr = 0; wr_seen = 0; rd_log_n = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
    check(all_done == 1'b0, "R11", "all_done cleared by start", int'(all_done), 0);
    if (poke_start) begin
      repeat (300) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      check(busy == 1'b1, "R2", "busy kept after start while busy", int'(busy), 1);
    end
    guard = 0;
    while (!all_done && guard < 20000) begin @(negedge clk); guard++; end
    check(all_done == 1'b1, "R9", "run completes", int'(all_done), 1);
    check(busy == 1'b0, "R9", "busy low with all_done", int'(busy), 0);
    check(wr_total == 256, "R6", "write count", wr_total, 256);
    check(rd_total == 2304, "R5", "read count", rd_total, 2304);
    check(order_bad == 0, "R7", "raster write order violations", order_bad, 0);
    for (int k = 0; k < 9; k++)
      check(rd_log[k] == (k / 3) * W + (k % 3), "R4", "first window read address",
            rd_log[k], (k / 3) * W + (k % 3));
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) begin
        int a = r * W + c;
        if (r == 0 || c == 0 || r == H - 1 || c == W - 1) begin
          check(wcnt[a] == 0, "R6", $sformatf("border write count at %0d", a), wcnt[a], 0);
        end else begin
          check(wcnt[a] == 1, "R6", $sformatf("interior write count at %0d", a), wcnt[a], 1);
          check(omem[a] == expect_at(r, c), tag, $sformatf("pixel (%0d,%0d)", r, c),
                omem[a], expect_at(r, c));
        end
      end
    repeat (20) @(negedge clk);
    check(all_done == 1'b1, "R9", "all_done held", int'(all_done), 1);
    check(busy == 1'b0, "R9", "stays idle", int'(busy), 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(!busy && !all_done && !rd_en && !wr_en, "R1", "outputs during reset",
          int'({busy, all_done, rd_en, wr_en}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !all_done && !rd_en && !wr_en, "R1", "outputs after reset",
          int'({busy, all_done, rd_en, wr_en}), 0);
    run_image(0, "R3 R8", 1'b0);
    run_image(1, "R10", 1'b0);
    run_image(2, "R10", 1'b0);
    run_image(3, "R3", 1'b1);   // R2: start pulse mid-run is ignored
    run_image(4, "R3 R11", 1'b0);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    wait (cycles >= 150000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule